// File: doc/BRIEF.md
# Dual-Output Level Interrupt Aggregator

This block collects up to 32 active-high, level-sensitive interrupt sources. It presents them as one read-only status word and routes them to four outputs. Two outputs are ordinary interrupt requests. The other two are machine-check requests. Each output has its own enable mask. Each source is brought into the clock domain through a two-flop synchroniser before it reaches the status word. Each output is a registered OR of the status bits that its mask enables.

Nothing needs to be acknowledged. An output stays high for as long as an enabled source is high. It falls only when the source drops or software clears the mask bit. The routes are independent, so one source may raise any number of outputs at the same time.

Software reaches the block over a simple word-wide register bus. A request is a single-cycle valid pulse qualified by a write flag. Read data is returned on the clock that follows the request. Every access is a whole word and there are no byte enables.

Top module: `irq_fanout`

## Requirements
- R1: Reading offset 0x00 returns the status word, where bit i is input i after two synchronising clock edges. The bit reads 1 for as long as the input is held high.
- R2: Offsets 0x10 and 0x14 hold the enable masks for interrupt outputs 0 and 1. Offsets 0x18 and 0x1C hold the enable masks for machine-check outputs 0 and 1. All four are written and read back as whole words.
- R3: Each output goes high when at least one status bit is high and its mask bit is 1. A mask bit of 1 enables the matching input.
- R4: When one input is enabled in several masks, every output whose mask enables it asserts in the same cycle.
- R5: No acknowledge exists. Reading status leaves the status word and the outputs unchanged, and an enabled asserted source keeps its outputs high.
- R6: After reset, all four masks read zero, all outputs are low and the read data is zero.
- R7: Writes to offset 0x00 or to any unmapped offset change no register. Reads of unmapped offsets return zero.
- R8: Read data appears on the clock after the read request and holds its value until the next read.
- R9: An output reflects a mask write one clock after the mask register updates. An input change reaches an output on the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | NUM_SRC | Level interrupt sources, active high |
| bus_valid | input | 1 | Register access request, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data, valid the clock after a read |
| irq_out | output | 2 | Interrupt request outputs 0 and 1 |
| mchk_out | output | 2 | Machine-check outputs 0 and 1 |

## Verification
The hardest state to reach is one where a single source drives several outputs at once while the masks for the other outputs stay clear. The stimulus has to line up the source pattern and all four mask words before the outputs settle. The bench gets there in two ways. Random source words are combined with independently drawn random masks, so overlaps of one bit and of many bits both occur. Directed steps also set the same bit in every mask and then remove it from one mask at a time, watching each output fall on the exact clock.

// File: rtl/irq_fanout.sv
module irq_fanout #(
  parameter int NUM_SRC     = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic [1:0]         irq_out,
  output logic [1:0]         mchk_out
);
  localparam int NUM_MASK = 4;
  localparam logic [ADDR_W-1:0] OFS_STATUS = '0;
  localparam int MASK_BASE = 16;

  logic [NUM_SRC-1:0] sync_q [SYNC_STAGES];
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask_q [NUM_MASK];
  logic [NUM_MASK-1:0] hit, out_q;
  logic [NUM_SRC-1:0] rd_mux;
  logic mapped;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= irq_src;

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
  end

  assign status = sync_q[SYNC_STAGES-1];

  for (genvar k = 0; k < NUM_MASK; k++) begin : g_mask
    assign hit[k] = (bus_addr == ADDR_W'(MASK_BASE + 4*k));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mask_q[k] <= '0;
      else if (bus_valid && bus_write && hit[k]) mask_q[k] <= bus_wdata;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) out_q[k] <= 1'b0;
      else        out_q[k] <= |(status & mask_q[k]);
  end

  assign irq_out  = out_q[1:0];
  assign mchk_out = out_q[3:2];
  assign mapped   = (bus_addr == OFS_STATUS) || (|hit);

  always_comb begin
    rd_mux = '0;
    if (bus_addr == OFS_STATUS) rd_mux = status;
    for (int k = 0; k < NUM_MASK; k++)
      if (hit[k]) rd_mux = mask_q[k];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_rdata <= '0;
    else if (bus_valid && !bus_write) bus_rdata <= rd_mux;

  logic [3:0] live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= '0;
    else if (live != 4'hF) live <= live + 4'd1;

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (live >= 4'(SYNC_STAGES)) |-> status == $past(irq_src, SYNC_STAGES)); // R1
  AST_IRQ0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[0] == '0) |=> !irq_out[0]); // R3
  AST_MCHK0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[2] == '0) |=> !mchk_out[0]); // R3
  AST_NO_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |=> (irq_out == 2'b00 && mchk_out == 2'b00)); // R5
  AST_IGNORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !(|hit)) |=>
      ($stable(mask_q[0]) && $stable(mask_q[1]) && $stable(mask_q[2]) && $stable(mask_q[3]))); // R7
  AST_UNMAPPED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !mapped) |=> bus_rdata == '0); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R8
endmodule

// File: tb/sim_irq_fanout.sv
`timescale 1ns/1ps
module sim_irq_fanout;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0] irq_out, mchk_out;
  int vectors = 0, errors = 0;
  bit done = 0;
  logic [31:0] m [4];

  always #2 clk = ~clk;

  irq_fanout u0 (.clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .mchk_out(mchk_out));

  function automatic logic [3:0] exp_out(logic [31:0] s);
    for (int k = 0; k < 4; k++) exp_out[k] = |(s & m[k]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic set_masks(logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [31:0] e);
    m[0] = a; m[1] = b; m[2] = c; m[3] = e;
    for (int k = 0; k < 4; k++) wr(8'h10 + 8'(4*k), m[k]);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, hold;
    void'($urandom(32'd2024));
    for (int k = 0; k < 4; k++) m[k] = '0;
    idle(2);
    rst_n = 1;
    @(negedge clk);
    // R6 reset state
    chk("R6 outputs", {28'd0, mchk_out, irq_out}, 32'd0);
    chk("R6 rdata", bus_rdata, 32'd0);
    for (int k = 0; k < 4; k++) begin
      rd(8'h10 + 8'(4*k), d);
      chk("R6 mask", d, 32'd0);
    end
    // R1 status reflects inputs
    irq_src = 32'hA5C3_0F81;
    idle(3);
    rd(8'h00, d);
    chk("R1 status", d, 32'hA5C3_0F81);
    chk("R3 masked off", {28'd0, mchk_out, irq_out}, 32'd0);
    // R2 mask readback
    set_masks(32'h0000_0001, 32'h8000_0000, 32'hFFFF_0000, 32'h0000_FFFF);
    for (int k = 0; k < 4; k++) begin
      rd(8'h10 + 8'(4*k), d);
      chk("R2 mask readback", d, m[k]);
    end
    idle(1);
    chk("R3 outputs", {28'd0, mchk_out, irq_out}, {28'd0, exp_out(irq_src)});
    // R4 one source on all outputs
    irq_src = 32'h0000_0020;
    set_masks(32'h20, 32'h20, 32'h20, 32'h20);
    idle(3);
    chk("R4 all four", {28'd0, mchk_out, irq_out}, 32'hF);
    // R5 reading status does not clear
    for (int i = 0; i < 3; i++) begin
      rd(8'h00, d);
      chk("R5 status held", d, 32'h20);
      chk("R5 outputs held", {28'd0, mchk_out, irq_out}, 32'hF);
    end
    // R9 mask latency: remove from one mask at a time
    for (int k = 0; k < 4; k++) begin
      m[k] = '0;
      wr(8'h10 + 8'(4*k), 32'h0);
      chk("R9 mask before", {28'd0, mchk_out, irq_out}, {28'd0, exp_out(32'h20) | (4'b1 << k)});
      @(negedge clk);
      chk("R9 mask after", {28'd0, mchk_out, irq_out}, {28'd0, exp_out(32'h20)});
    end
    // R9 input latency
    set_masks(32'h1, 32'h0, 32'h0, 32'h0);
    irq_src = '0;
    idle(4);
    irq_src = 32'h1;
    idle(2);
    chk("R9 input two edges", {30'd0, irq_out}, 32'd0);
    @(negedge clk);
    chk("R9 input third edge", {30'd0, irq_out}, 32'd1);
    irq_src = '0;
    idle(3);
    chk("R5 falls with source", {30'd0, irq_out}, 32'd0);
    // R7 ignored writes and unmapped reads
    set_masks(32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F, 32'hF0F0_F0F0);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      rd(8'h10 + 8'(4*k), d);
      chk("R7 mask untouched", d, m[k]);
    end
    rd(8'h00, d);
    chk("R7 status untouched", d, 32'h0);
    rd(8'h04, d);
    chk("R7 unmapped read", d, 32'h0);
    rd(8'h1D, d);
    chk("R7 unaligned read", d, 32'h0);
    // R8 hold
    rd(8'h14, hold);
    chk("R8 read value", hold, m[1]);
    irq_src = 32'hFFFF_FFFF;
    wr(8'h14, 32'h0);
    m[1] = '0;
    idle(3);
    chk("R8 rdata holds", bus_rdata, hold);
    // random mix
    for (int n = 0; n < 60; n++) begin
      irq_src = $urandom;
      if (n % 3 == 0) irq_src = irq_src & $urandom & $urandom;
      set_masks($urandom & $urandom, $urandom & $urandom, $urandom & $urandom & $urandom, $urandom & $urandom);
      idle(3);
      chk("R3 random outputs", {28'd0, mchk_out, irq_out}, {28'd0, exp_out(irq_src)});
      rd(8'h00, d);
      chk("R1 random status", d, irq_src);
      rd(8'h10 + 8'(4*($urandom % 4)), d);
      vectors++;
      if (d !== m[0] && d !== m[1] && d !== m[2] && d !== m[3]) begin
        errors++;
        $display("FAIL R2 random readback: got %h expected one of the masks", d);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule